// File: doc/BRIEF.md
# Programmable Timer Counter Channel

This block is a single 16-bit down-counting channel of an interval timer. A count-enable strobe (`tick`) advances it, and a `gate` input controls it. A register interface supplies an initial count and a 3-bit mode through a one-cycle `load` strobe. The channel presents its live count, which the surrounding logic reads or latches, and an output pin level. The output pin can serve as an interrupt source, a one-shot pulse or a square wave.

Six behaviours are selected by the mode value:
- **Mode 0:** interrupt on terminal count.
- **Mode 1:** gate-retriggered one-shot.
- **Mode 2:** periodic rate strobe.
- **Mode 3:** square wave.
- **Mode 4:** software-started strobe.
- **Mode 5:** gate-started strobe.

Mode values 6 and 7 alias the two periodic modes. An initial count of zero stands for 65536 ticks. Depending on the mode, the gate either enables counting by level or restarts the sequence on its rising edge. The gate is sampled into a register on the system clock, and edges are found against that copy.

Decimal counting and address decoding belong to the surrounding logic.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count is 0 and the output is high. The mode is 0 and no load has been seen, so ticks do not change the count.
- R2: A `load` pulse sets the count to `load_val` and captures `mode` for all later behaviour. In mode 3, bit 0 of the loaded value is cleared. A load restarts the sequence and takes priority over a tick or gate edge in the same cycle.
- R3: A loaded value of 0 acts as 65536. The count wraps from 0 to 0xFFFF on the next tick, and in mode 2 the period is 65536 ticks.
- R4: Modes 0 and 4 subtract one per tick while `gate` is high and wrap modulo 2^16. While `gate` is low the count holds, and a gate rising edge does not reload.
- R5: In mode 0 the output goes low on load. It goes high when the count reaches 0 and stays high through later wraps until the next load.
- R6: In modes 4 and 5 the output is high, except low from the tick that first brings the count to 0 until the next counting tick.
- R7: In modes 1 and 5 the count holds after a load until a gate rising edge. Each rising edge reloads the initial count and starts counting by one per tick, regardless of the gate level.
- R8: In mode 1 the output is high until the trigger, low while counting, and high from the tick that brings the count to 0.
- R9: In mode 2 a tick at count 1 reloads the initial count; otherwise the count drops by one. The output is low exactly while the count is 1 and the gate is high.
- R10: In mode 3 the count drops by two per tick. A tick at count 2 reloads the initial count and inverts the output, which starts high after a load. The count stays even.
- R11: In modes 2 and 3 a low gate holds the count and forces the output high. A gate rising edge reloads the initial count with the output high.
- R12: The 3-bit mode value n selects mode n for n = 0 to 5. Values 6 and 7 behave as modes 2 and 3.
- R13: With no load, no tick and no gate rising edge, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable strobe, one count step per clock it is high |
| gate | input | 1 | Gate input, level enable or rising-edge trigger depending on mode |
| load | input | 1 | One-cycle strobe that loads `load_val` and `mode` |
| load_val | input | CNT_W | Initial count |
| mode | input | 3 | Mode selector, captured on `load` |
| count | output | CNT_W | Current count value |
| out_pin | output | 1 | Channel output level |

## Verification
The bench uses the default `CNT_W` of 16, so the count range and wrap are those of the real channel. At that width a zero load in rate mode runs its full 65536-tick period in roughly 65 thousand clocks. This shows that zero acts as 65536 and that the output falls at count 1 at the very end of that period. The table walk drives all eight mode encodings, including both aliases and an odd square-wave load. Directed sequences cover gate suspension, retriggering, and load priority over a simultaneous tick.

// File: rtl/tmr_channel_pkg.sv
`timescale 1ns/1ps
package tmr_channel_pkg;

    localparam int MODE_W = 3;

    // Operating modes after aliasing
    typedef enum logic [MODE_W-1:0] {
        M_INT      = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    // Progress of a one-pass count sequence
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // waiting for first load or for a gate trigger
        PH_RUN  = 2'd1,  // counting towards zero
        PH_TERM = 2'd2,  // count just reached zero
        PH_DONE = 2'd3   // past terminal count, still wrapping
    } phase_e;

    // Values 6 and 7 fold onto the two periodic modes
    function automatic mode_e norm_mode(input logic [MODE_W-1:0] m);
        if (m[2] && m[1]) begin
            return mode_e'({1'b0, m[1:0]});
        end
        return mode_e'(m);
    endfunction

    function automatic phase_e phase_after_step(input phase_e ph, input logic at_one);
        phase_e r;
        r = ph;
        if (ph == PH_RUN && at_one) begin
            r = PH_TERM;
        end else if (ph == PH_TERM) begin
            r = PH_DONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_gate_sync.sv
`timescale 1ns/1ps
module tmr_gate_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_q,
    output logic gate_rise
);
    logic gate_d;

    always_comb begin
        gate_d    = gate;
        gate_rise = gate && !gate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr_channel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic              gate_rise,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [MODE_W-1:0] mode_in,
    output logic [CNT_W-1:0]  count_q,
    output mode_e             mode_q,
    output phase_e            phase_q,
    output logic              sq_q
);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);
    localparam logic [CNT_W-1:0] EVEN_MASK = ~ONE;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] init;
        mode_e            mode;
        phase_e           phase;
        logic             sq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    mode_e    mode_new;

    always_comb begin
        st_d     = st_q;
        mode_new = norm_mode(mode_in);
        if (load) begin
            st_d.init  = load_val;
            st_d.mode  = mode_new;
            st_d.sq    = 1'b1;
            st_d.count = (mode_new == M_SQUARE) ? (load_val & EVEN_MASK) : load_val;
            st_d.phase = (mode_new == M_ONESHOT || mode_new == M_HWSTROBE) ? PH_IDLE : PH_RUN;
        end else begin
            case (st_q.mode)
                M_INT, M_SWSTROBE: begin
                    // level-gated single-step counting, edges ignored
                    if (tick && gate && st_q.phase != PH_IDLE) begin
                        st_d.count = st_q.count - ONE;
                        st_d.phase = phase_after_step(st_q.phase, st_q.count == ONE);
                    end
                end
                M_ONESHOT, M_HWSTROBE: begin
                    // edge-triggered, gate level irrelevant once started
                    if (gate_rise) begin
                        st_d.count = st_q.init;
                        st_d.phase = PH_RUN;
                    end else if (tick && st_q.phase != PH_IDLE) begin
                        st_d.count = st_q.count - ONE;
                        st_d.phase = phase_after_step(st_q.phase, st_q.count == ONE);
                    end
                end
                M_RATE: begin
                    if (gate_rise) begin
                        st_d.count = st_q.init;
                    end else if (tick && gate) begin
                        st_d.count = (st_q.count == ONE) ? st_q.init : st_q.count - ONE;
                    end
                end
                M_SQUARE: begin
                    if (!gate) begin
                        st_d.sq = 1'b1;
                    end else if (gate_rise) begin
                        st_d.count = st_q.init & EVEN_MASK;
                        st_d.sq    = 1'b1;
                    end else if (tick) begin
                        if (st_q.count == TWO) begin
                            st_d.count = st_q.init & EVEN_MASK;
                            st_d.sq    = !st_q.sq;
                        end else begin
                            st_d.count = st_q.count - TWO;
                        end
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '0;
            st_q.init  <= '0;
            st_q.mode  <= M_INT;
            st_q.phase <= PH_IDLE;
            st_q.sq    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign mode_q  = st_q.mode;
    assign phase_q = st_q.phase;
    assign sq_q    = st_q.sq;
endmodule

// File: rtl/tmr_out_decode.sv
`timescale 1ns/1ps
module tmr_out_decode
    import tmr_channel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  mode_e            mode_q,
    input  phase_e           phase_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic             sq_q,
    input  logic             gate_q,
    output logic             out_pin
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        case (mode_q)
            M_INT, M_ONESHOT:       out_pin = (phase_q != PH_RUN);
            M_SWSTROBE, M_HWSTROBE: out_pin = (phase_q != PH_TERM);
            M_RATE:                 out_pin = !gate_q || (count_q != ONE);
            M_SQUARE:               out_pin = sq_q;
            default:                out_pin = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_channel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  count,
    output logic              out_pin
);
    logic   gate_q;
    logic   gate_rise;
    mode_e  mode_q;
    phase_e phase_q;
    logic   sq_q;

    tmr_gate_sync u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .gate_q    (gate_q),
        .gate_rise (gate_rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .gate      (gate),
        .gate_rise (gate_rise),
        .load      (load),
        .load_val  (load_val),
        .mode_in   (mode),
        .count_q   (count),
        .mode_q    (mode_q),
        .phase_q   (phase_q),
        .sq_q      (sq_q)
    );

    tmr_out_decode #(.CNT_W(CNT_W)) u_out (
        .mode_q  (mode_q),
        .phase_q (phase_q),
        .count_q (count),
        .sq_q    (sq_q),
        .gate_q  (gate_q),
        .out_pin (out_pin)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk
    import tmr_channel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count,
    input logic             out_pin,
    input mode_e            mode_q,
    input phase_e           phase_q,
    input logic             gate_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((count | ONE) == ($past(load_val) | ONE)));  // R2

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick && !(gate && !gate_q)) |=> $stable(count));  // R13

    AST_LEVEL_MODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && gate && mode_q == M_INT && phase_q != PH_IDLE)
        |=> (count == $past(count) - ONE));  // R4

    AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SQUARE) |-> !count[0]);  // R10

    AST_RATE_LOW_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_RATE && !out_pin) |-> (count == ONE));  // R9

    AST_STROBE_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_pin) |-> (count == '0));  // R6

    AST_PERIODIC_GATE_LOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate_q) |-> out_pin);  // R11

    AST_TRIGGER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_ONESHOT || mode_q == M_HWSTROBE) && phase_q == PH_IDLE
         && !load && !(gate && !gate_q)) |=> $stable(count));  // R7
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gate     (gate),
    .load     (load),
    .load_val (load_val),
    .count    (count),
    .out_pin  (out_pin),
    .mode_q   (mode_q),
    .phase_q  (phase_q),
    .gate_q   (gate_q)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
    localparam int CNT_W   = 16;
    localparam int N_VEC   = 15;
    localparam int WD_CYC  = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             gate = 1'b1;
    logic             load = 1'b0;
    logic [CNT_W-1:0] load_val = '0;
    logic [2:0]       mode = 3'd0;
    logic [CNT_W-1:0] count;
    logic             out_pin;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tmr_channel #(.CNT_W(CNT_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .load     (load),
        .load_val (load_val),
        .mode     (mode),
        .count    (count),
        .out_pin  (out_pin)
    );

    // {mode[3], init[16], ticks[16], expected count[16], expected out[1]}
    localparam logic [51:0] VEC [N_VEC] = '{
        {3'd0, 16'd5,  16'd3, 16'd2,      1'b0},  // R5 counting, out low
        {3'd0, 16'd5,  16'd5, 16'd0,      1'b1},  // R5 terminal count
        {3'd0, 16'd0,  16'd1, 16'hFFFF,   1'b0},  // R3 zero load wraps
        {3'd0, 16'd3,  16'd5, 16'hFFFE,   1'b1},  // R5 stays high after wrap
        {3'd2, 16'd4,  16'd3, 16'd1,      1'b0},  // R9 low at one
        {3'd2, 16'd4,  16'd4, 16'd4,      1'b1},  // R9 reload
        {3'd2, 16'd4,  16'd6, 16'd2,      1'b1},  // R9 second period
        {3'd3, 16'd6,  16'd2, 16'd2,      1'b1},  // R10 first half
        {3'd3, 16'd6,  16'd3, 16'd6,      1'b0},  // R10 toggle
        {3'd3, 16'd6,  16'd6, 16'd6,      1'b1},  // R10 full period
        {3'd4, 16'd3,  16'd3, 16'd0,      1'b0},  // R6 strobe low
        {3'd4, 16'd3,  16'd4, 16'hFFFF,   1'b1},  // R6 strobe over
        {3'd6, 16'd4,  16'd3, 16'd1,      1'b0},  // R12 alias of rate
        {3'd7, 16'd6,  16'd3, 16'd6,      1'b0},  // R12 alias of square
        {3'd3, 16'd7,  16'd1, 16'd4,      1'b1}   // R2 odd load cleared
    };

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0:       return "R5";
            3'd2:       return "R9";
            3'd3:       return "R10";
            3'd4:       return "R6";
            default:    return "R12";
        endcase
    endfunction

    task automatic chk_cnt(input string req, input logic [CNT_W-1:0] exp);
        checks++;
        if (count !== exp) begin
            failures++;
            $display("FAIL %s count actual=%h expected=%h", req, count, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic exp);
        checks++;
        if (out_pin !== exp) begin
            failures++;
            $display("FAIL %s out_pin actual=%b expected=%b", req, out_pin, exp);
        end
    endtask

    // all drive tasks start and end 1 ns after a rising edge
    task automatic do_load(input logic [2:0] m, input logic [CNT_W-1:0] v);
        mode = m; load_val = v; load = 1'b1;
        @(posedge clk); #1;
        load = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(posedge clk);
            #1;
            tick = 1'b0;
        end
    endtask

    task automatic set_gate(input logic v);
        gate = v;
        @(posedge clk); #1;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    task automatic resume;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        resume();

        // R1: reset state, ticks ignored before any load
        settle();
        chk_cnt("R1", '0);
        chk_out("R1", 1'b1);
        resume();
        do_ticks(3);
        settle();
        chk_cnt("R1", '0);
        chk_out("R1", 1'b1);
        resume();

        // table walk, gate held high
        for (int i = 0; i < N_VEC; i++) begin
            do_load(VEC[i][51:49], VEC[i][48:33]);
            do_ticks(int'(VEC[i][32:17]));
            settle();
            chk_cnt(tag_of(VEC[i][51:49]), VEC[i][16:1]);
            chk_out(tag_of(VEC[i][51:49]), VEC[i][0]);
            resume();
        end

        // R13: no event, no change
        do_load(3'd0, 16'd20);
        repeat (5) resume();
        settle();
        chk_cnt("R13", 16'd20);
        resume();

        // R4: gate level suspends mode 0, rising edge does not reload
        do_load(3'd0, 16'd10);
        do_ticks(2);
        gate = 1'b0;
        do_ticks(3);
        settle();
        chk_cnt("R4", 16'd8);
        resume();
        set_gate(1'b1);
        settle();
        chk_cnt("R4", 16'd8);
        chk_out("R5", 1'b0);
        resume();
        do_ticks(1);
        settle();
        chk_cnt("R4", 16'd7);
        resume();

        // R2: load wins over a simultaneous tick, restarts mode 0 with out low
        do_ticks(8);
        tick = 1'b1;
        do_load(3'd0, 16'd9);
        tick = 1'b0;
        settle();
        chk_cnt("R2", 16'd9);
        chk_out("R2", 1'b0);
        resume();

        // R7 / R8: mode 1 waits, triggers, ignores level, retriggers
        do_load(3'd1, 16'd4);
        do_ticks(3);
        settle();
        chk_cnt("R7", 16'd4);
        chk_out("R8", 1'b1);
        resume();
        set_gate(1'b0);
        set_gate(1'b1);
        settle();
        chk_cnt("R7", 16'd4);
        chk_out("R8", 1'b0);
        resume();
        gate = 1'b0;
        do_ticks(2);
        settle();
        chk_cnt("R7", 16'd2);
        resume();
        set_gate(1'b1);
        settle();
        chk_cnt("R7", 16'd4);
        resume();
        do_ticks(4);
        settle();
        chk_cnt("R8", 16'd0);
        chk_out("R8", 1'b1);
        resume();

        // R6 / R7: mode 5 strobe after gate trigger
        do_load(3'd5, 16'd3);
        set_gate(1'b0);
        set_gate(1'b1);
        do_ticks(3);
        settle();
        chk_cnt("R6", 16'd0);
        chk_out("R6", 1'b0);
        resume();
        do_ticks(1);
        settle();
        chk_cnt("R6", 16'hFFFF);
        chk_out("R6", 1'b1);
        resume();

        // R11: mode 2 gate low holds and forces high, edge reloads
        do_load(3'd2, 16'd5);
        do_ticks(4);
        settle();
        chk_out("R9", 1'b0);
        resume();
        set_gate(1'b0);
        do_ticks(2);
        settle();
        chk_cnt("R11", 16'd1);
        chk_out("R11", 1'b1);
        resume();
        set_gate(1'b1);
        settle();
        chk_cnt("R11", 16'd5);
        chk_out("R11", 1'b1);
        resume();

        // R11: mode 3 gate low forces high, edge reloads
        do_load(3'd3, 16'd8);
        do_ticks(4);
        settle();
        chk_cnt("R10", 16'd8);
        chk_out("R10", 1'b0);
        resume();
        gate = 1'b0;
        do_ticks(2);
        settle();
        chk_cnt("R11", 16'd8);
        chk_out("R11", 1'b1);
        resume();
        set_gate(1'b1);
        do_ticks(1);
        settle();
        chk_cnt("R11", 16'd6);
        chk_out("R11", 1'b1);
        resume();

        // R3: zero load in mode 2 gives a 65536-tick period
        do_load(3'd2, 16'd0);
        do_ticks(65535);
        settle();
        chk_cnt("R3", 16'd1);
        chk_out("R3", 1'b0);
        resume();
        do_ticks(1);
        settle();
        chk_cnt("R3", 16'd0);
        chk_out("R3", 1'b1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule